// File: doc/BRIEF.md
# Link Self-Test Pattern Sequencer

This block is the transmit-side self-test controller for a serial link of ten lanes. Software programs it through a small register port. The registers hold a 24-bit test pattern, a mask that picks which lanes take part, the lengths of the test phases, a calibration switch and a start bit. Once started, the block walks through four phases in a fixed order: an optional calibration handshake, a quiet phase of programmed length, a run of first-kind training sequences, and a run of second-kind training sequences. The second-kind run either stops after a programmed number of repeats or continues until software clears the start bit.

During both training phases every selected lane carries the pattern as two 12-bit frames that alternate, low half first. Unselected lanes, and all lanes outside the training phases, carry the idle word 0. Calibration is reduced to a request/done handshake with the rest of the chip. The phase, a busy flag and a done flag are visible at the ports, so a bench or a link manager can follow the run.

Top module: `lane_selftest_seq`

## Requirements
- R1: After reset, address 0 reads 0x00FD3302, address 1 reads 0, and address 2 reads 0x0C801402. In the control word at address 2, bit 0 is start, bit 1 is calibration enable, bits 11:2 are the quiet count (reset 0x100), bits 19:12 are the second-kind count (reset 0x01), bits 29:20 are the first-kind count (reset 0x0C8), and the rest read 0.
- R2: A write to address 0 keeps only bits 23:0 of the data, and the read shows bits 31:24 as 0. A write to address 1 keeps bits 9:0, where bit i selects lane i. Address 3 reads 0.
- R3: The phase output encodes IDLE=0, CALIB=1, QUIET=2, TS0=3, TS1=4 and DONE=5. On the clock edge after start reads 1, the phase leaves IDLE. It goes to CALIB when calibration is enabled. CALIB holds calibReq high and is left on the first edge at which calibDone is 1.
- R4: QUIET lasts exactly the quiet count in cycles. A count of 0 skips the phase.
- R5: TS0 lasts 4 cycles per sequence, times the first-kind count. A count of 0 skips the phase.
- R6: When bit 7 of the second-kind count is 0, TS1 lasts 4 times that count in cycles and is followed by DONE. A count of 0 goes straight to DONE. DONE holds while start stays 1.
- R7: When bit 7 of the second-kind count is 1, TS1 never ends by itself.
- R8: In TS0 and TS1, slots 0 and 2 of each 4-cycle sequence put pattern bits 11:0 on every selected lane, and slots 1 and 3 put bits 23:12. Lane i occupies laneData bits 12i+11:12i. Unselected lanes, and all lanes in the other phases, output 0.
- R9: The pattern, the lane mask and the counts are captured on the edge that leaves IDLE. Register writes made later have no effect on the running test.
- R10: When start reads 0, the phase is IDLE after the next clock edge, whatever the current phase.
- R11: busy is 1 in CALIB, QUIET, TS0 and TS1 only. done is 1 in DONE only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| cfgWrEn | input | 1 | Register write strobe |
| cfgAddr | input | 2 | Register address |
| cfgWrData | input | 32 | Register write data |
| cfgRdData | output | 32 | Register read data (combinational on cfgAddr) |
| calibDone | input | 1 | Calibration finished |
| calibReq | output | 1 | Calibration requested |
| phase | output | 3 | Current phase code |
| laneData | output | 120 | One 12-bit frame per lane |
| busy | output | 1 | Test in progress |
| done | output | 1 | Test finished |

## Verification
The assertions watch the rules that hold cycle by cycle:
- lanes idle outside the training phases;
- a return to IDLE one edge after start drops;
- CALIB held until calibDone;
- DONE held while start stays 1;
- busy and done never high together;
- the upper pattern byte reading zero.

Phase lengths, the alternation of pattern halves, the lane mask, the loop-forever case and the way captured settings ignore later writes only show up across whole runs. The bench covers these by following every random and directed run with its own reference model, cycle by cycle.

// File: rtl/lts_pkg.sv
package lts_pkg;
  localparam int FRAME_W = 12;
  localparam int PAT_W   = 2 * FRAME_W;
  localparam int TS0_W   = 10;
  localparam int TS1_W   = 8;
  localparam int DIS_W   = 10;
  localparam int CNT_W   = (TS0_W > DIS_W) ? TS0_W : DIS_W;
  localparam int SLOT_W  = 2;   // four frame slots per training sequence

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_CALIB = 3'd1,
    PH_QUIET = 3'd2,
    PH_TS0   = 3'd3,
    PH_TS1   = 3'd4,
    PH_DONE  = 3'd5
  } phase_e;

  // control word, most significant member first
  typedef struct packed {
    logic [TS0_W-1:0] ts0Cnt;
    logic [TS1_W-1:0] ts1Cnt;
    logic [DIS_W-1:0] disCnt;
    logic             calibEn;
    logic             start;
  } ctrlCfg_t;

  localparam int CTRL_W = $bits(ctrlCfg_t);

  typedef struct packed {
    logic capture;   // latch pattern and mask for this run
    logic drive;     // lanes carry pattern frames
    logic highHalf;  // select upper half of the pattern
  } dpStrobe_t;

  localparam logic [PAT_W-1:0] PAT_RST  = 24'hFD3302;
  localparam ctrlCfg_t         CTRL_RST = '{ts0Cnt: 10'h0C8, ts1Cnt: 8'h01,
                                            disCnt: 10'h100, calibEn: 1'b1,
                                            start: 1'b0};
endpackage

// File: rtl/lts_datapath.sv
module lts_datapath
  import lts_pkg::*;
#(
  parameter int NLANES = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [1:0]                cfgAddr,
  input  logic [31:0]               cfgWrData,
  output logic [31:0]               cfgRdData,
  output ctrlCfg_t                  cfg,
  input  dpStrobe_t                 strobe,
  output logic [NLANES*FRAME_W-1:0] laneData
);
  logic [PAT_W-1:0]  patReg, patSnap;
  logic [NLANES-1:0] maskReg, maskSnap;
  ctrlCfg_t          ctrlReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patReg  <= PAT_RST;
      maskReg <= '0;
      ctrlReg <= CTRL_RST;
    end else if (cfgWrEn) begin
      case (cfgAddr)
        2'd0:    patReg  <= cfgWrData[PAT_W-1:0];
        2'd1:    maskReg <= cfgWrData[NLANES-1:0];
        2'd2:    ctrlReg <= ctrlCfg_t'(cfgWrData[CTRL_W-1:0]);
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      patSnap  <= PAT_RST;
      maskSnap <= '0;
    end else if (strobe.capture) begin
      patSnap  <= patReg;
      maskSnap <= maskReg;
    end
  end

  always_comb begin
    case (cfgAddr)
      2'd0:    cfgRdData = 32'(patReg);
      2'd1:    cfgRdData = 32'(maskReg);
      2'd2:    cfgRdData = 32'(ctrlReg);
      default: cfgRdData = '0;
    endcase
  end

  assign cfg = ctrlReg;

  logic [FRAME_W-1:0] curFrame;
  assign curFrame = strobe.highHalf ? patSnap[PAT_W-1:FRAME_W] : patSnap[FRAME_W-1:0];

  for (genvar g = 0; g < NLANES; g++) begin : gLane
    assign laneData[g*FRAME_W +: FRAME_W] =
      (strobe.drive && maskSnap[g]) ? curFrame : '0;
  end
endmodule

// File: rtl/lts_ctrl.sv
module lts_ctrl
  import lts_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  ctrlCfg_t  cfg,
  input  logic      calibDone,
  output dpStrobe_t strobe,
  output phase_e    phase,
  output logic      calibReq,
  output logic      busy,
  output logic      done
);
  phase_e             state, nxt;
  logic [SLOT_W-1:0]  slot;
  logic [CNT_W-1:0]   cnt;
  logic [DIS_W-1:0]   disSnap;
  logic [TS0_W-1:0]   ts0Snap;
  logic [TS1_W-1:0]   ts1Snap;
  logic [CNT_W-1:0]   ts1Lim;
  logic               lastSlot, leaveIdle;

  // phase that follows a finished one, skipping phases whose count is zero
  function automatic phase_e follow(input phase_e from, input logic [DIS_W-1:0] d,
                                    input logic [TS0_W-1:0] t0, input logic [TS1_W-1:0] t1);
    phase_e r;
    if (from == PH_CALIB && d != '0)
      r = PH_QUIET;
    else if ((from == PH_CALIB || from == PH_QUIET) && t0 != '0)
      r = PH_TS0;
    else if (from != PH_TS1 && t1 != '0)
      r = PH_TS1;
    else
      r = PH_DONE;
    return r;
  endfunction

  assign lastSlot  = (slot == SLOT_W'(3));
  assign leaveIdle = (state == PH_IDLE) && cfg.start;
  assign ts1Lim    = CNT_W'(ts1Snap[TS1_W-2:0]);

  always_comb begin
    nxt = state;
    case (state)
      PH_IDLE:  if (cfg.start)
                  nxt = cfg.calibEn ? PH_CALIB
                                    : follow(PH_CALIB, cfg.disCnt, cfg.ts0Cnt, cfg.ts1Cnt);
      PH_CALIB: if (calibDone) nxt = follow(PH_CALIB, disSnap, ts0Snap, ts1Snap);
      PH_QUIET: if (cnt == CNT_W'(disSnap) - 1'b1)
                  nxt = follow(PH_QUIET, disSnap, ts0Snap, ts1Snap);
      PH_TS0:   if (lastSlot && cnt == CNT_W'(ts0Snap) - 1'b1)
                  nxt = follow(PH_TS0, disSnap, ts0Snap, ts1Snap);
      PH_TS1:   if (!ts1Snap[TS1_W-1] && lastSlot && cnt == ts1Lim - 1'b1)
                  nxt = PH_DONE;
      default:  nxt = state;
    endcase
    if (!cfg.start) nxt = PH_IDLE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= PH_IDLE;
      slot    <= '0;
      cnt     <= '0;
      disSnap <= '0;
      ts0Snap <= '0;
      ts1Snap <= '0;
    end else begin
      state <= nxt;
      if (leaveIdle) begin
        disSnap <= cfg.disCnt;
        ts0Snap <= cfg.ts0Cnt;
        ts1Snap <= cfg.ts1Cnt;
      end
      if (nxt != state) begin
        slot <= '0;
        cnt  <= '0;
      end else if (state == PH_TS0 || state == PH_TS1) begin
        slot <= slot + 1'b1;
        if (lastSlot) cnt <= cnt + 1'b1;
      end else if (state == PH_QUIET) begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  assign strobe.capture  = leaveIdle;
  assign strobe.drive    = (state == PH_TS0) || (state == PH_TS1);
  assign strobe.highHalf = slot[0];

  assign phase    = state;
  assign calibReq = (state == PH_CALIB);
  assign busy     = (state != PH_IDLE) && (state != PH_DONE);
  assign done     = (state == PH_DONE);
endmodule

// File: rtl/lane_selftest_seq.sv
module lane_selftest_seq
  import lts_pkg::*;
#(
  parameter int NLANES = 10
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      cfgWrEn,
  input  logic [1:0]                cfgAddr,
  input  logic [31:0]               cfgWrData,
  output logic [31:0]               cfgRdData,
  input  logic                      calibDone,
  output logic                      calibReq,
  output logic [2:0]                phase,
  output logic [NLANES*FRAME_W-1:0] laneData,
  output logic                      busy,
  output logic                      done
);
  ctrlCfg_t  cfg;
  dpStrobe_t strobe;
  phase_e    phaseState;
  logic      startBit;

  assign startBit = cfg.start;
  assign phase    = phaseState;

  lts_datapath #(.NLANES(NLANES)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .cfg(cfg),
    .strobe(strobe), .laneData(laneData)
  );

  lts_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfg(cfg), .calibDone(calibDone),
    .strobe(strobe), .phase(phaseState), .calibReq(calibReq),
    .busy(busy), .done(done)
  );
endmodule

// File: rtl/lts_checker.sv
module lts_checker #(
  parameter int NLANES = 10,
  parameter int FW     = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               startBit,
  input logic               calibDone,
  input logic               calibReq,
  input logic [2:0]         phase,
  input logic [NLANES*FW-1:0] laneData,
  input logic               busy,
  input logic               done,
  input logic [1:0]         cfgAddr,
  input logic [31:0]        cfgRdData
);
  localparam logic [2:0] IDLE = 3'd0, CALIB = 3'd1, TS0 = 3'd3, TS1 = 3'd4, DONE = 3'd5;

  a_r8_quiet_lanes: assert property (@(posedge clk) disable iff (!rstN)
    (phase != TS0 && phase != TS1) |-> laneData == '0);

  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    !startBit |=> phase == IDLE);

  a_r3_leave_idle: assert property (@(posedge clk) disable iff (!rstN)
    (phase == IDLE && startBit) |=> phase != IDLE);

  a_r3_calib_hold: assert property (@(posedge clk) disable iff (!rstN)
    (phase == CALIB && !calibDone && startBit) |=> (phase == CALIB && calibReq));

  a_r6_done_holds: assert property (@(posedge clk) disable iff (!rstN)
    (phase == DONE && startBit) |=> phase == DONE);

  a_r11_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  a_r2_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    cfgAddr == 2'd0 |-> cfgRdData[31:24] == 8'h00);
endmodule

bind lane_selftest_seq lts_checker #(.NLANES(NLANES), .FW(lts_pkg::FRAME_W)) u_chk (
  .clk(clk), .rstN(rstN), .startBit(startBit), .calibDone(calibDone),
  .calibReq(calibReq), .phase(phase), .laneData(laneData), .busy(busy),
  .done(done), .cfgAddr(cfgAddr), .cfgRdData(cfgRdData)
);

// File: tb/lane_selftest_seq_bench.sv
module lane_selftest_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NL = 10;
  localparam int FW = 12;

  logic clk = 1'b0, rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgAddr = '0;
  logic [31:0] cfgWrData = '0;
  logic [31:0] cfgRdData;
  logic calibDone = 1'b0, calibReq, busy, done;
  logic [2:0] phase;
  logic [NL*FW-1:0] laneData;

  int checks = 0, fails = 0;
  bit midWrite = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lane_selftest_seq u_lane_selftest_seq (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr),
    .cfgWrData(cfgWrData), .cfgRdData(cfgRdData), .calibDone(calibDone),
    .calibReq(calibReq), .phase(phase), .laneData(laneData), .busy(busy), .done(done)
  );

  // ---------------- reference model, built from the requirements ----------------
  logic [23:0] mPat, mPatS;
  logic [9:0]  mMask, mMaskS;
  logic [29:0] mCtrl;
  logic [2:0]  mState;
  logic [1:0]  mSlot;
  logic [9:0]  mCnt, mDis, mTs0;
  logic [7:0]  mTs1;

  function automatic logic [2:0] followPh(logic [2:0] from, logic [9:0] d, logic [9:0] t0, logic [7:0] t1);
    if (from == 3'd1 && d != 0) return 3'd2;
    if ((from == 3'd1 || from == 3'd2) && t0 != 0) return 3'd3;
    if (from != 3'd4 && t1 != 0) return 3'd4;
    return 3'd5;
  endfunction

  always @(posedge clk or negedge rstN) begin
    logic [2:0] n;
    if (!rstN) begin
      mPat <= 24'hFD3302; mMask <= '0; mCtrl <= 30'h0C801402;
      mPatS <= 24'hFD3302; mMaskS <= '0;
      mState <= 3'd0; mSlot <= '0; mCnt <= '0; mDis <= '0; mTs0 <= '0; mTs1 <= '0;
    end else begin
      n = mState;
      case (mState)
        3'd0: if (mCtrl[0]) n = mCtrl[1] ? 3'd1 : followPh(3'd1, mCtrl[11:2], mCtrl[29:20], mCtrl[19:12]);
        3'd1: if (calibDone) n = followPh(3'd1, mDis, mTs0, mTs1);
        3'd2: if (mCnt == mDis - 10'd1) n = followPh(3'd2, mDis, mTs0, mTs1);
        3'd3: if (mSlot == 2'd3 && mCnt == mTs0 - 10'd1) n = followPh(3'd3, mDis, mTs0, mTs1);
        3'd4: if (!mTs1[7] && mSlot == 2'd3 && mCnt == {3'd0, mTs1[6:0]} - 10'd1) n = 3'd5;
        default: ;
      endcase
      if (!mCtrl[0]) n = 3'd0;
      if (mState == 3'd0 && mCtrl[0]) begin
        mPatS <= mPat; mMaskS <= mMask;
        mDis <= mCtrl[11:2]; mTs0 <= mCtrl[29:20]; mTs1 <= mCtrl[19:12];
      end
      if (n != mState) begin mSlot <= '0; mCnt <= '0; end
      else if (mState == 3'd3 || mState == 3'd4) begin
        mSlot <= mSlot + 2'd1;
        if (mSlot == 2'd3) mCnt <= mCnt + 10'd1;
      end else if (mState == 3'd2) mCnt <= mCnt + 10'd1;
      mState <= n;
      if (cfgWrEn) case (cfgAddr)
        2'd0: mPat <= cfgWrData[23:0];
        2'd1: mMask <= cfgWrData[9:0];
        2'd2: mCtrl <= cfgWrData[29:0];
        default: ;
      endcase
    end
  end

  function automatic logic [NL*FW-1:0] expLanes(logic [2:0] ph, logic [1:0] sl, logic [9:0] mk, logic [23:0] pt);
    logic [NL*FW-1:0] r = '0;
    if (ph == 3'd3 || ph == 3'd4)
      for (int i = 0; i < NL; i++)
        if (mk[i]) r[i*FW +: FW] = sl[0] ? pt[23:12] : pt[11:0];
    return r;
  endfunction

  function automatic string phTag(logic [2:0] ph, logic [7:0] t1);
    case (ph)
      3'd0: return "R10";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return t1[7] ? "R7" : "R6";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic compareAll();
    check({phTag(mState, mTs1), " phase"}, 128'(phase), 128'(mState));
    check(midWrite ? "R9 lanes" : "R8 lanes", 128'(laneData), 128'(expLanes(mState, mSlot, mMaskS, mPatS)));
    check("R11 busy", 128'(busy), 128'(mState != 3'd0 && mState != 3'd5));
    check("R11 done", 128'(done), 128'(mState == 3'd5));
    check("R3 calibReq", 128'(calibReq), 128'(mState == 3'd1));
  endtask

  function automatic logic [31:0] mkCtrl(bit st, bit cal, logic [9:0] d, logic [7:0] t1, logic [9:0] t0);
    return {2'b00, t0, t1, d, cal, st};
  endfunction

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    compareAll();
    cfgWrEn = 1'b1; cfgAddr = a; cfgWrData = d;
    @(negedge clk);
    compareAll();
    cfgWrEn = 1'b0;
  endtask

  task automatic rdCheck(string tag, logic [1:0] a, logic [31:0] exp);
    @(negedge clk);
    cfgAddr = a;
    #1;
    check(tag, 128'(cfgRdData), 128'(exp));
  endtask

  // runs until the model reaches DONE (plus a few cycles) or the cycle limit
  task automatic runTest(int maxCyc, bit allowWr);
    int tail = 0;
    for (int c = 0; c < maxCyc && tail < 3; c++) begin
      @(negedge clk);
      compareAll();
      if (mState == 3'd5) tail++;
      calibDone = ($urandom % 3) == 0;
      cfgWrEn = 1'b0;
      if (allowWr && mState != 3'd0 && ($urandom % 8) == 0) begin
        cfgWrEn = 1'b1; cfgAddr = 2'($urandom % 2); cfgWrData = $urandom;
        midWrite = 1;
      end
    end
    @(negedge clk);
    compareAll();
    cfgWrEn = 1'b0; calibDone = 1'b0;
  endtask

  task automatic stopTest();
    wr(2'd2, mkCtrl(0, mCtrl[1], mCtrl[11:2], mCtrl[19:12], mCtrl[29:20]));
    repeat (2) begin @(negedge clk); compareAll(); end
    midWrite = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", checks - fails, checks + 1);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1 reset state
    rdCheck("R1 pattern", 2'd0, 32'h00FD3302);
    rdCheck("R1 mask", 2'd1, 32'h0);
    rdCheck("R1 control", 2'd2, 32'h0C801402);
    @(negedge clk); compareAll();
    // R2 write masking
    wr(2'd0, 32'hFFFFFFFF); rdCheck("R2 pattern upper", 2'd0, 32'h00FFFFFF);
    wr(2'd1, 32'hFFFFFFFF); rdCheck("R2 mask", 2'd1, 32'h000003FF);
    wr(2'd3, 32'h12345678); rdCheck("R2 spare", 2'd3, 32'h0);
    // full run with reset counts and calibration
    wr(2'd0, 32'h00ABC123); wr(2'd1, 32'h2A5);
    wr(2'd2, mkCtrl(1, 1, 10'h100, 8'h01, 10'h0C8));
    runTest(2000, 0);
    stopTest();
    // all counts zero, no calibration: straight to DONE (R4 R5 R6)
    wr(2'd2, mkCtrl(1, 0, 0, 0, 0));
    runTest(20, 0);
    stopTest();
    // loop forever, then stop during TS1 (R7 R10)
    wr(2'd1, 32'h3FF);
    wr(2'd2, mkCtrl(1, 0, 10'd2, 8'h83, 10'd1));
    runTest(200, 1);
    check("R7 still running", 128'(phase), 128'(3'd4));
    stopTest();
    // stop during TS0 (R10)
    wr(2'd2, mkCtrl(1, 1, 10'd3, 8'd2, 10'd9));
    runTest(12, 0);
    stopTest();
    // random runs with later writes (R9)
    for (int s = 0; s < 30; s++) begin
      logic [7:0] t1;
      t1 = ($urandom % 6 == 0) ? 8'(8'h80 | ($urandom % 128)) : 8'($urandom % 7);
      wr(2'd0, $urandom);
      wr(2'd1, $urandom);
      wr(2'd2, mkCtrl(1, 1'($urandom % 2), 10'($urandom % 12), t1, 10'($urandom % 8)));
      runTest(150, 1);
      stopTest();
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule